// File: doc/BRIEF.md
# DDR Read/Write Data-Window Timer

This block sits beside a DDR memory command scheduler. Each time the scheduler issues a read or a write column command, the block works out, cycle by cycle, when read data will arrive from the memory and when write data has to be put on the bus. It raises a read-data-valid window and a write-data-enable window of the right length at the right time. For each window it also gives a beat index that names the pair of data transfers moving on the current clock.

The read latency is the additive (posted) latency plus the CAS latency. The write latency is one clock less than that. A window lasts half the burst length in clocks, because data moves on both clock edges. Every accepted command drops a start marker into its own delay line. Commands that are in flight together therefore each get their own window, and closely spaced commands give back-to-back windows. The latency and burst settings are copied from the configuration inputs only while nothing is in flight. A setting outside the supported range is refused.

Top module: `ddr_lat_pipe`

## Requirements
- R1: After reset both windows are low, both beat indices are 0, and the active setting is CAS latency 3, additive latency 0, burst length 4.
- R2: A read accepted in cycle c (cmd_valid=1, cmd_wr=0) raises rd_valid first in cycle c + AL + CL.
- R3: A write accepted in cycle c (cmd_valid=1, cmd_wr=1) raises wr_en first in cycle c + AL + CL - 1.
- R4: A window lasts 2 clocks when cfg_bl8=0 (burst of 4) and 4 clocks when cfg_bl8=1 (burst of 8).
- R5: The beat index is 0 in the first clock of a window and rises by 2 on each following clock of it. A value n means beats n and n+1 move in that clock. Outside a window it is 0.
- R6: Commands of one kind spaced exactly BL/2 cycles apart give one continuous window, and the beat index restarts at 0 for each command.
- R7: A read window and a write window that overlap in time are both produced in full.
- R8: The configuration inputs (cfg_cl = CAS latency in binary, cfg_al = additive latency in binary, cfg_bl8) are taken only at a clock edge where no command is in flight, no window is open and cmd_valid is 0. Commands keep using the old setting until then.
- R9: A setting with cfg_cl outside 3..6 or cfg_al above 5 is refused as a whole, and the previous setting stays active.
- R10: A command whose window starts before the previous window of the same kind has ended restarts that window. The beat index goes back to 0 and a full window follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A column command is accepted this cycle |
| cmd_wr | input | 1 | 1 = write command, 0 = read command |
| cfg_cl | input | 3 | Requested CAS latency, 3..6 |
| cfg_al | input | 3 | Requested additive latency, 0..5 |
| cfg_bl8 | input | 1 | Requested burst length: 1 = 8, 0 = 4 |
| rd_valid | output | 1 | Read data returns this clock |
| rd_beat | output | 3 | Index of the first read beat in this clock |
| wr_en | output | 1 | Write data must be driven this clock |
| wr_beat | output | 3 | Index of the first write beat in this clock |

## Verification
The bench builds the block with its default parameters: CAS latency up to 6, additive latency up to 5 and an 11-stage delay line. These values let it sweep all 48 combinations of latency and burst length. In each combination the start cycle and length of both windows are compared with arithmetic predictions. Directed sequences then reach the longest delay line position, windows laid back to back, overlapping read and write windows, a restarted window, and a setting change that arrives while commands are in flight or is out of range.

// File: rtl/ddr_lat_pipe.sv
module ddr_lat_pipe #(
  parameter int CL_MIN = 3,
  parameter int CL_MAX = 6,
  parameter int AL_MAX = 5,
  parameter int CFG_W  = 3,
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_wr,
  input  logic [CFG_W-1:0]  cfg_cl,
  input  logic [CFG_W-1:0]  cfg_al,
  input  logic              cfg_bl8,
  output logic              rd_valid,
  output logic [BEAT_W-1:0] rd_beat,
  output logic              wr_en,
  output logic [BEAT_W-1:0] wr_beat
);
  localparam int DEPTH = CL_MAX + AL_MAX;
  localparam int LW    = $clog2(DEPTH + 1);

  logic [CFG_W-1:0]  cl_q, al_q;
  logic              bl8_q;
  logic [DEPTH-1:0]  rd_sr, wr_sr;
  logic [1:0]        rd_cnt, wr_cnt;
  logic [BEAT_W-1:0] rd_pos, wr_pos;

  logic [LW-1:0]    rl;
  logic [DEPTH-1:0] rd_ins, wr_ins;
  logic [1:0]       tail;
  logic             cfg_legal, idle;

  assign rl     = LW'(al_q) + LW'(cl_q);
  assign rd_ins = (cmd_valid && !cmd_wr) ? (DEPTH'(1) << (rl - LW'(1))) : '0;
  assign wr_ins = (cmd_valid &&  cmd_wr) ? (DEPTH'(1) << (rl - LW'(2))) : '0;
  assign tail   = bl8_q ? 2'd3 : 2'd1;

  assign cfg_legal = (int'(cfg_cl) >= CL_MIN) && (int'(cfg_cl) <= CL_MAX) &&
                     (int'(cfg_al) <= AL_MAX);
  assign idle = !cmd_valid && (rd_sr == '0) && (wr_sr == '0) &&
                (rd_cnt == 2'd0) && (wr_cnt == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cl_q  <= CFG_W'(CL_MIN);
      al_q  <= '0;
      bl8_q <= 1'b0;
    end else if (idle && cfg_legal) begin
      cl_q  <= cfg_cl;
      al_q  <= cfg_al;
      bl8_q <= cfg_bl8;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_sr <= '0;
      wr_sr <= '0;
    end else begin
      rd_sr <= (rd_sr >> 1) | rd_ins;
      wr_sr <= (wr_sr >> 1) | wr_ins;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt <= '0;
      rd_pos <= '0;
    end else if (rd_sr[0]) begin
      rd_cnt <= tail;
      rd_pos <= BEAT_W'(2);
    end else if (rd_cnt != 2'd0) begin
      rd_cnt <= rd_cnt - 2'd1;
      rd_pos <= rd_pos + BEAT_W'(2);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt <= '0;
      wr_pos <= '0;
    end else if (wr_sr[0]) begin
      wr_cnt <= tail;
      wr_pos <= BEAT_W'(2);
    end else if (wr_cnt != 2'd0) begin
      wr_cnt <= wr_cnt - 2'd1;
      wr_pos <= wr_pos + BEAT_W'(2);
    end
  end

  assign rd_valid = rd_sr[0] || (rd_cnt != 2'd0);
  assign wr_en    = wr_sr[0] || (wr_cnt != 2'd0);
  assign rd_beat  = (!rd_sr[0] && rd_cnt != 2'd0) ? rd_pos : '0;
  assign wr_beat  = (!wr_sr[0] && wr_cnt != 2'd0) ? wr_pos : '0;
endmodule

module ddr_lat_pipe_chk #(
  parameter int CFG_W  = 3,
  parameter int BEAT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_valid,
  input logic [BEAT_W-1:0] rd_beat,
  input logic              wr_en,
  input logic [BEAT_W-1:0] wr_beat,
  input logic [CFG_W-1:0]  cl_q,
  input logic [CFG_W-1:0]  al_q,
  input logic              bl8_q
);
  p_rd_beat_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_beat == '0);
  p_wr_beat_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> wr_beat == '0);
  p_rd_beat_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_beat != '0) |-> (rd_beat == $past(rd_beat) + BEAT_W'(2)));
  p_rd_beat_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_beat <= (bl8_q ? BEAT_W'(6) : BEAT_W'(2)));
  p_wr_beat_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_beat <= (bl8_q ? BEAT_W'(6) : BEAT_W'(2)));
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || wr_en) |=> ($stable(cl_q) && $stable(al_q) && $stable(bl8_q)));
  p_cfg_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_q >= CFG_W'(3)) && (cl_q <= CFG_W'(6)) && (al_q <= CFG_W'(5)));
endmodule

bind ddr_lat_pipe ddr_lat_pipe_chk #(.CFG_W(CFG_W), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_beat(rd_beat),
  .wr_en(wr_en), .wr_beat(wr_beat), .cl_q(cl_q), .al_q(al_q), .bl8_q(bl8_q)
);

// File: tb/ddr_lat_pipe_bench.sv
module ddr_lat_pipe_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [2:0] cfg_cl = 3'd0;
  logic [2:0] cfg_al = 3'd0;
  logic       cfg_bl8 = 1'b0;
  logic       rd_valid, wr_en;
  logic [2:0] rd_beat, wr_beat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cmdk [WIN];
  int rs_half [2*WIN];
  int ws_half [2*WIN];

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_lat_pipe u_ddr_lat_pipe (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_wr(cmd_wr),
    .cfg_cl(cfg_cl), .cfg_al(cfg_al), .cfg_bl8(cfg_bl8),
    .rd_valid(rd_valid), .rd_beat(rd_beat), .wr_en(wr_en), .wr_beat(wr_beat)
  );

  task automatic clear_cmds();
    for (int i = 0; i < WIN; i++) cmdk[i] = 0;
  endtask

  function automatic void expect_at(input int k, input bit is_wr,
                                    output bit v, output int beat);
    v = 1'b0;
    beat = 0;
    for (int s = k; s >= 0; s--) begin
      int h;
      h = is_wr ? ws_half[s] : rs_half[s];
      if (h != 0) begin
        if (k - s < h) begin
          v = 1'b1;
          beat = 2 * (k - s);
        end
        break;
      end
    end
  endfunction

  // Commands before cycle 20 use setting A; later ones use setting B.
  task automatic run_test(input string tag,
                          input int a_cl, input int a_al, input int a_b8,
                          input int rl_a, input int half_a,
                          input int b_cl, input int b_al, input int b_b8,
                          input int rl_b, input int half_b);
    int errs;
    string msg;
    cfg_cl = 3'(a_cl); cfg_al = 3'(a_al); cfg_bl8 = 1'(a_b8);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2*WIN; i++) begin rs_half[i] = 0; ws_half[i] = 0; end
    for (int k = 0; k < WIN; k++) begin
      int rl, h;
      rl = (k < 20) ? rl_a : rl_b;
      h  = (k < 20) ? half_a : half_b;
      if (cmdk[k] == 1) rs_half[k + rl] = h;
      if (cmdk[k] == 2) ws_half[k + rl - 1] = h;
    end
    errs = 0;
    for (int k = 0; k < WIN; k++) begin
      if (k > 0) begin
        bit erv, ewv;
        int erb, ewb;
        expect_at(k, 1'b0, erv, erb);
        expect_at(k, 1'b1, ewv, ewb);
        if (errs == 0 && (rd_valid !== erv || int'(rd_beat) != erb ||
                          wr_en !== ewv || int'(wr_beat) != ewb)) begin
          $sformat(msg, "cycle %0d rd=%0b/%0d wr=%0b/%0d expected rd=%0b/%0d wr=%0b/%0d",
                   k, rd_valid, rd_beat, wr_en, wr_beat, erv, erb, ewv, ewb);
          errs++;
        end
      end
      cmd_valid = (cmdk[k] != 0);
      cmd_wr    = (cmdk[k] == 2);
      if (k == 1) begin
        cfg_cl = 3'(b_cl); cfg_al = 3'(b_al); cfg_bl8 = 1'(b_b8);
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    checks++;
    if (errs != 0) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0 || wr_en !== 1'b0 || rd_beat !== 3'd0 || wr_beat !== 3'd0) begin
      errors++;
      $display("FAIL R1 in reset: rd=%b/%0d wr=%b/%0d expected 0/0 0/0",
               rd_valid, rd_beat, wr_en, wr_beat);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 and R9: illegal CL=0 leaves the reset setting (rl 3, burst 4) active
    clear_cmds(); cmdk[0] = 1; cmdk[25] = 2;
    run_test("R1/R9 reset setting", 0, 0, 1, 3, 2, 0, 0, 1, 3, 2);

    // R2 R3 R4 R5: sweep every legal setting
    for (int cl = 3; cl <= 6; cl++)
      for (int al = 0; al <= 5; al++)
        for (int b8 = 0; b8 <= 1; b8++) begin
          string t;
          $sformat(t, "R2/R3/R4/R5 CL=%0d AL=%0d BL=%0d", cl, al, b8 ? 8 : 4);
          clear_cmds(); cmdk[0] = 1; cmdk[25] = 2;
          run_test(t, cl, al, b8, cl + al, b8 ? 4 : 2, cl, al, b8, cl + al, b8 ? 4 : 2);
        end

    // R6: reads and writes spaced BL/2 apart
    clear_cmds(); cmdk[0] = 1; cmdk[4] = 1; cmdk[8] = 1; cmdk[30] = 2; cmdk[34] = 2;
    run_test("R6 back to back", 4, 2, 1, 6, 4, 4, 2, 1, 6, 4);

    // R7: read and write windows overlap
    clear_cmds(); cmdk[0] = 1; cmdk[2] = 2; cmdk[24] = 2; cmdk[25] = 1;
    run_test("R7 overlap", 5, 0, 0, 5, 2, 5, 0, 0, 5, 2);

    // R10: second read lands inside the first window
    clear_cmds(); cmdk[0] = 1; cmdk[2] = 1;
    run_test("R10 restart", 3, 0, 1, 3, 4, 3, 0, 1, 3, 4);

    // R8: setting changed while busy applies only after idle
    clear_cmds(); cmdk[0] = 1; cmdk[3] = 1; cmdk[22] = 2;
    run_test("R8 change while busy", 3, 0, 0, 3, 2, 6, 5, 1, 11, 4);

    // R9: out-of-range CL and AL refused
    clear_cmds(); cmdk[0] = 1; cmdk[22] = 1;
    run_test("R9 bad CL", 4, 1, 1, 5, 4, 7, 0, 0, 5, 4);
    clear_cmds(); cmdk[0] = 2; cmdk[22] = 2;
    run_test("R9 bad AL", 4, 1, 1, 5, 4, 3, 6, 0, 5, 4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule